// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Tagged Character Queue

This block turns an asynchronous serial line into a queue of received characters. The raw line is first brought into the clock domain through a short chain of flops that come out of reset at the idle (high) level. Bit timing comes only from a one-clock enable pulse that arrives sixteen times per bit period; the divider that makes that pulse lives outside. A format input sets the word length, the number of stop bits and the parity rules, and every frame is checked against it.

Each finished character goes into a sixteen-deep queue as an 11-bit word that carries its own break, parity-error and framing-error tags. The host takes words through a valid/ready output port: a word leaves the queue on any clock where `m_valid` and `m_ready` are both high. `m_ready` may be held high freely; while the queue is empty it has no effect. The receive side has no back-pressure: a character that arrives while the queue is full is dropped and raises a sticky overrun flag. The block also reports the fill level, a flag that is set while any stored word carries an error tag, and an idle counter that signals a character timeout while data waits in the queue.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the line is taken as idle: `m_valid`, `fill_level`, `overrun`, `err_any` and `char_timeout` are all 0, and no character is produced.
- R2: The receiver advances only on clocks where `baud_tick` is high; a low line with no ticks produces no character.
- R3: Each output word holds the character in bits [10:3] (right-aligned, the first bit on the line in bit 3), break in bit 2, parity error in bit 1 and framing error in bit 0. `line_fmt[1:0]` of 0, 1, 2, 3 selects 5, 6, 7, 8 data bits, and `line_fmt[2]` adds a second stop bit.
- R4: `char_stb` is high for exactly one clock per received character, in the clock where the word enters the queue.
- R5: `line_fmt[3]` enables a parity bit after the data. With `line_fmt[5]` low the bit makes the count of ones even when `line_fmt[4]` is 1 and odd when it is 0; with `line_fmt[5]` high the bit must be 0 if `line_fmt[4]` is 1 and 1 otherwise. A mismatch sets the parity-error tag.
- R6: A start bit is confirmed at the middle of the bit; if the line is high by then, the receiver returns to idle and stores nothing.
- R7: A frame whose data bits, parity bit (when enabled) and first stop bit are all low is stored with both the break and framing tags set.
- R8: `fill_level` counts stored words from 0 to 16; a pulse on `fifo_clr` empties the queue and clears `err_any`.
- R9: A character arriving while 16 words are stored and no word leaves is dropped and sets `overrun`, which stays set until a pulse on `err_ack`.
- R10: A word that arrives in the same clock as a word leaves is stored, and `fill_level` is unchanged.
- R11: The idle counter reloads to 64 times the frame length in bits, minus 1, on every arrival, departure or `fifo_clr`, and counts down once per tick to 0. `char_timeout` is high when it is 0 and the queue is not empty.
- R12: `err_any` is high while any stored word has a nonzero tag.
- R13: A word leaves only when `m_valid` and `m_ready` are both high; while `m_valid` is high and `m_ready` low, `m_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Raw serial input, idle high |
| baud_tick | input | 1 | One-clock pulse at sixteen times the bit rate |
| line_fmt | input | 6 | Frame format: [1:0] length, [2] stop bits, [3] parity on, [4] even, [5] stick |
| fifo_clr | input | 1 | Empties the queue |
| err_ack | input | 1 | Clears the overrun flag |
| m_data | output | 11 | Head word: character and tags |
| m_valid | output | 1 | Queue holds at least one word |
| m_ready | input | 1 | Host takes the head word |
| char_stb | output | 1 | One-clock strobe per stored character |
| fill_level | output | 5 | Number of stored words |
| overrun | output | 1 | Sticky overrun flag |
| err_any | output | 1 | Some stored word carries an error tag |
| idle_cnt | output | 10 | Character-timeout counter |
| char_timeout | output | 1 | Counter at 0 with data waiting |

## Verification
The line passes two sync flops, so the frame logic sees an edge two clocks late, and a word is stored in the clock after the stop-bit sample. `char_stb`, `fill_level`, `m_valid` and `err_any` therefore move one clock after that sample, and `overrun` moves in the same clock as the rejected store. The bench checks queue results only after a whole frame and a full idle bit have gone by, which is far later than any of these delays. It reads the idle counter at the first falling edge after a reload, before any tick can lower it. It tests the timeout on both sides of its window, with a margin of several ticks.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [7:0] ch;
    logic       brk;
    logic       perr;
    logic       ferr;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  function automatic logic [3:0] word_len(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    return 4'd2 + word_len(fmt[1:0]) + {3'b000, fmt[3]} + {3'b000, fmt[2]};
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic [5:0] fmt,
  output logic      push,
  output rx_word_t  word
);
  rx_state_e  state;
  logic [3:0] ph;
  logic [2:0] nbit;
  logic [7:0] shreg;
  logic       perr_r;
  logic       plow_r;
  logic [3:0] wl;
  logic       exp_par;

  assign wl = word_len(fmt[1:0]);
  assign exp_par = fmt[5] ? ~fmt[4] : (fmt[4] ? ^shreg : ~^shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      ph     <= '0;
      nbit   <= '0;
      shreg  <= '0;
      perr_r <= 1'b0;
      plow_r <= 1'b0;
      push   <= 1'b0;
      word   <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx) begin
              state <= RX_START;
              ph    <= '0;
            end
          end
          RX_START: begin
            ph <= ph + 4'd1;
            if (ph == 4'd7) begin
              ph    <= '0;
              nbit  <= '0;
              shreg <= '0;
              state <= rx ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            ph <= ph + 4'd1;
            if (ph == 4'd15) begin
              shreg <= {rx, shreg[7:1]};
              nbit  <= nbit + 3'd1;
              if ({1'b0, nbit} == wl - 4'd1) state <= fmt[3] ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: begin
            ph <= ph + 4'd1;
            if (ph == 4'd15) begin
              perr_r <= rx ^ exp_par;
              plow_r <= ~rx;
              state  <= RX_STOP;
            end
          end
          RX_STOP: begin
            ph <= ph + 4'd1;
            if (ph == 4'd15) begin
              push      <= 1'b1;
              word.ch   <= shreg >> (4'd8 - wl);
              word.ferr <= ~rx;
              word.perr <= fmt[3] & perr_r;
              word.brk  <= (shreg == 8'h00) && !rx && (!fmt[3] || plow_r);
              state     <= rx ? RX_IDLE : RX_HOLD;
            end
          end
          RX_HOLD: begin
            if (rx) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R4: a store strobe never lasts two clocks
  p_push_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R6: a start bit seen high at mid-bit is dropped
  p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && tick && ph == 4'd7 && rx) |=> (state == RX_IDLE && !push));

  // R2: without a tick the receiver state holds
  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  parameter int TAG_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  input  logic                       ack,
  output logic                       overrun,
  output logic                       err_any
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [DEPTH-1:0] errv;
  logic [AW-1:0] wptr, rptr;
  logic          is_full, do_rd, do_wr;

  assign is_full = (count == CW'(DEPTH));
  assign do_rd   = rd && (count != '0);
  assign do_wr   = wr && (!is_full || do_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      errv  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      errv  <= '0;
    end else begin
      if (do_rd) begin
        errv[rptr] <= 1'b0;
        rptr       <= rptr + 1'b1;
      end
      if (do_wr) begin
        mem[wptr]  <= wdata;
        errv[wptr] <= |wdata[TAG_W-1:0];
        wptr       <= wptr + 1'b1;
      end
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               overrun <= 1'b0;
    else if (wr && !do_wr)    overrun <= 1'b1;
    else if (ack)             overrun <= 1'b0;
  end

  assign rdata   = mem[rptr];
  assign err_any = |errv;

  // R8: occupancy never exceeds the depth
  p_count_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8: a clear empties the queue and its error summary
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !err_any));

  // R10: simultaneous store and take keep the count
  p_pushpop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd && count != '0 && !clr) |=> (count == $past(count)));

  // R9: a store into a full queue with no take raises overrun
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && count == CW'(DEPTH)) |=> overrun);
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout
  import serial_rx_pkg::*;
#(
  parameter int TO_W = 10,
  parameter int MULT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [3:0]      fmt,
  input  logic            reload,
  input  logic            has_data,
  output logic [TO_W-1:0] cnt,
  output logic            timeout
);
  logic [TO_W-1:0] reload_val;

  assign reload_val = TO_W'(int'(frame_bits(fmt)) * MULT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (reload)                 cnt <= reload_val;
    else if (tick && cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign timeout = (cnt == '0) && has_data;

  // R11: one step down per tick between reloads
  p_tick_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R11: no movement without a tick or reload
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !tick) |=> $stable(cnt));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TO_W  = 10,
  parameter int SYNC  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_line,
  input  logic                   baud_tick,
  input  logic [5:0]             line_fmt,
  input  logic                   fifo_clr,
  input  logic                   err_ack,
  output logic [WORD_W-1:0]      m_data,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic                   char_stb,
  output logic [$clog2(DEPTH):0] fill_level,
  output logic                   overrun,
  output logic                   err_any,
  output logic [TO_W-1:0]        idle_cnt,
  output logic                   char_timeout
);
  logic     rx_s;
  rx_word_t word;
  logic     take;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
  );

  rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_s),
    .fmt(line_fmt), .push(char_stb), .word(word)
  );

  rx_fifo #(.DEPTH(DEPTH), .W(WORD_W), .TAG_W(3)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr(char_stb), .wdata(word),
    .rd(m_ready), .rdata(m_data), .count(fill_level), .ack(err_ack),
    .overrun(overrun), .err_any(err_any)
  );

  assign m_valid = (fill_level != '0);
  assign take    = m_valid && m_ready;

  rx_timeout #(.TO_W(TO_W), .MULT(64)) u_timeout (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .fmt(line_fmt[3:0]),
    .reload(char_stb || take || fifo_clr), .has_data(m_valid),
    .cnt(idle_cnt), .timeout(char_timeout)
  );

  // R13: a word waiting without ready stays put
  p_hold_head_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !fifo_clr) |=> (m_valid && $stable(m_data)));
endmodule

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        baud_tick = 1'b0;
  logic [5:0]  line_fmt = 6'h03;
  logic        fifo_clr = 1'b0;
  logic        err_ack = 1'b0;
  logic [10:0] m_data;
  logic        m_valid;
  logic        m_ready_man = 1'b0;
  logic        follow = 1'b0;
  logic        m_ready;
  logic        char_stb;
  logic [4:0]  fill_level;
  logic        overrun, err_any, char_timeout;
  logic [9:0]  idle_cnt;

  int tests = 0, fails = 0, wide = 0;
  bit done = 0;
  logic tick_en = 1'b1;
  logic [1:0] tdiv = '0;
  logic stb_q = 1'b0;

  assign m_ready = follow ? char_stb : m_ready_man;

  always #4 clk = ~clk;

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .line_fmt(line_fmt), .fifo_clr(fifo_clr), .err_ack(err_ack),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .char_stb(char_stb), .fill_level(fill_level), .overrun(overrun),
    .err_any(err_any), .idle_cnt(idle_cnt), .char_timeout(char_timeout)
  );

  always @(posedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= tick_en && (tdiv == 2'd3);
    stb_q     <= char_stb;
    if (stb_q && char_stb) wide <= wide + 1;
  end

  // fmt, data, bad parity, stop level, expected word
  localparam logic [28:0] VEC [0:10] = '{
    {8'h03, 8'hA5, 1'b0, 1'b1, 11'h528},
    {8'h00, 8'h15, 1'b0, 1'b1, 11'h0A8},
    {8'h1B, 8'h3C, 1'b0, 1'b1, 11'h1E0},
    {8'h1B, 8'h3C, 1'b1, 1'b1, 11'h1E2},
    {8'h0B, 8'h01, 1'b0, 1'b1, 11'h008},
    {8'h03, 8'h7E, 1'b0, 1'b0, 11'h3F1},
    {8'h3B, 8'hFF, 1'b0, 1'b1, 11'h7F8},
    {8'h02, 8'h55, 1'b0, 1'b1, 11'h2A8},
    {8'h03, 8'h00, 1'b0, 1'b0, 11'h005},
    {8'h07, 8'h81, 1'b0, 1'b1, 11'h408},
    {8'h1B, 8'h00, 1'b0, 1'b0, 11'h005}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk) rx_line = v;
    wait_ticks(16);
  endtask

  task automatic send_frame(input logic [7:0] fmt, input logic [7:0] data,
                            input logic badpar, input logic stopv);
    int wl;
    logic [7:0] d;
    logic p;
    wl = 5 + int'(fmt[1:0]);
    d = data & 8'((1 << wl) - 1);
    p = fmt[5] ? ~fmt[4] : (fmt[4] ? ^d : ~^d);
    p = p ^ badpar;
    send_bit(1'b0);
    for (int i = 0; i < wl; i++) send_bit(d[i]);
    if (fmt[3]) send_bit(p);
    send_bit(stopv);
    if (fmt[2]) send_bit(stopv);
    send_bit(1'b1);
  endtask

  task automatic take_one();
    @(negedge clk) m_ready_man = 1'b1;
    @(negedge clk) m_ready_man = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) fifo_clr = 1'b1;
    @(negedge clk) fifo_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", m_valid, 0);
    check("R1 fill", fill_level, 0);
    check("R1 overrun", overrun, 0);
    check("R1 err_any", err_any, 0);
    check("R1 timeout", char_timeout, 0);
    wait_ticks(40);
    check("R1 no char", fill_level, 0);

    // R3 R5 R7: table of frames
    for (int k = 0; k < 11; k++) begin
      line_fmt = VEC[k][26:21];
      send_frame(VEC[k][28:21], VEC[k][20:13], VEC[k][12], VEC[k][11]);
      check("R3 R5 R7 valid", m_valid, 1);
      check("R3 R5 R7 word", m_data, VEC[k][10:0]);
      take_one();
      check("R13 drained", fill_level, 0);
    end
    check("R4 strobe width", wide, 0);

    // R2: no ticks, no progress
    line_fmt = 6'h03;
    tick_en = 1'b0;
    @(negedge clk) rx_line = 1'b0;
    repeat (2000) @(negedge clk);
    rx_line = 1'b1;
    tick_en = 1'b1;
    wait_ticks(60);
    check("R2 no char", fill_level, 0);

    // R6: short low pulse is rejected
    @(negedge clk) rx_line = 1'b0;
    wait_ticks(3);
    @(negedge clk) rx_line = 1'b1;
    wait_ticks(200);
    check("R6 rejected", fill_level, 0);

    // R13: ready with empty queue has no effect
    take_one();
    check("R13 empty take", fill_level, 0);

    // R8 R9 R12: fill past capacity
    for (int k = 0; k < 17; k++) begin
      send_frame(8'h03, 8'(8'h10 + k), 1'b0, (k == 3) ? 1'b0 : 1'b1);
      if (k == 15) begin
        check("R8 full", fill_level, 16);
        check("R9 no overrun yet", overrun, 0);
      end
    end
    check("R9 overrun", overrun, 1);
    check("R9 fill kept", fill_level, 16);
    check("R9 head kept", m_data, 11'h080);
    check("R12 err_any", err_any, 1);
    @(negedge clk) err_ack = 1'b1;
    @(negedge clk) err_ack = 1'b0;
    check("R9 ack clears", overrun, 0);
    pulse_clr();
    check("R8 clr fill", fill_level, 0);
    check("R8 clr valid", m_valid, 0);
    check("R12 clr err", err_any, 0);

    // R10: store and take in one clock
    send_frame(8'h03, 8'h41, 1'b0, 1'b1);
    send_frame(8'h03, 8'h42, 1'b0, 1'b1);
    check("R10 pre", fill_level, 2);
    follow = 1'b1;
    send_frame(8'h03, 8'h43, 1'b0, 1'b1);
    follow = 1'b0;
    check("R10 count held", fill_level, 2);
    check("R10 head", m_data, 11'h210);
    take_one();
    check("R10 tail", m_data, 11'h218);
    pulse_clr();

    // R11: timeout window, 5N1 reload 7*64-1 = 447
    line_fmt = 6'h00;
    send_frame(8'h00, 8'h0A, 1'b0, 1'b1);
    check("R11 no timeout early", char_timeout, 0);
    wait_ticks(400);
    check("R11 still counting", char_timeout, 0);
    wait_ticks(40);
    check("R11 timeout", char_timeout, 1);
    check("R11 cnt zero", idle_cnt, 0);
    take_one();
    check("R11 reload on take", idle_cnt, 447);
    check("R11 empty no timeout", char_timeout, 0);
    wait_ticks(500);
    check("R11 empty stays", char_timeout, 0);
    // R11: 8 bits, parity, two stops -> 12*64-1 = 767
    line_fmt = 6'h0F;
    pulse_clr();
    check("R11 format reload", idle_cnt, 767);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule